// File: doc/BRIEF.md
# Debug Event Status and Delayed Interrupt Controller

This block gathers single-cycle debug event pulses from twelve sources into a sticky status register and decides when the core should see a debug interrupt request. Recording does not depend on the global debug-enable bit. The interrupt, however, is delivered only while that bit is 1. An event that arrives while debug is disabled stays pending. The request rises as soon as a configuration write turns debug on.

Each event resource is owned either by software debug or by an external debugger. Ownership matters only while external-debug mode is on. Events on externally owned resources are still recorded, but they never raise the software request. When a software-owned event becomes recorded while debug is disabled, an imprecise flag is set. This flag tells the handler that the saved return address belongs to the instruction that enabled delivery, not to the instruction that caused the event. A separate input selects whether the return state goes to the debug save/restore pair or to the critical pair.

The twelve event bits carry no priority. Their index assignment is instruction address compare 0, data address compare 1, trap 2, branch taken 3, instruction complete 4, interrupt taken 5, return 6, unconditional 7, external event A 8, external event B 9, critical interrupt taken 10, critical return 11.

Top module: `dbg_event_ctrl`

## Requirements
- R1: After reset, `status`, `imprecise`, `irq`, `dben`, `precise`, `extmode` and `own_ext` are all 0.
- R2: An event pulse on bit i sets `status[i]` at the next rising edge, whatever the value of `dben`.
- R3: Status bits are sticky. A bit clears only on a cycle with `clr_wr`=1 and `clr_mask[i]`=1. If an event on the same bit arrives in that same cycle, the event wins and the bit stays 1.
- R4: A resource i is software-owned when `extmode`=0, or when `own_ext[i]`=0. `irq` is 1 exactly when `dben`=1 and some software-owned status bit is 1. It is driven combinationally from registered state.
- R5: An event recorded while `dben`=0 leaves `irq` at 0. `irq` becomes 1 in the cycle after a configuration write that sets `dben` to 1.
- R6: A configuration write (`cfg_wr`=1) loads `dben`, `precise` and `extmode` together at the next edge. A write that leaves both `dben` and `precise` at 1, while a software-owned status bit recorded earlier is still set, raises `irq` at that edge.
- R7: `imprecise` is set at the next edge when a status bit goes from 0 to 1 while the previously held `dben` is 0 and that resource is software-owned. The bit does not go from 0 to 1 when a new event arrives on a bit that is already set.
- R8: `imprecise` is not set by events recorded while `dben`=1, nor by events on externally owned resources while `extmode`=1. It clears only when `clr_wr`=1 and `clr_imp`=1, and a setting event in the same cycle wins.
- R9: When `extmode`=1 and `own_ext[i]`=1, an event on bit i sets `status[i]` but never raises `irq`. Ownership (`own_wr` loads `own_ext`, 1 means externally owned) has no effect while `extmode`=0.
- R10: `irq` falls in the cycle after the clear write that removes the last software-owned status bit.
- R11: `use_debug_pair` equals `dbg_ext_en` (1 selects the debug save/restore pair, 0 the critical pair). `ret_from_enabler` equals `imprecise`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | NEV | Event pulses, one bit per source |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Debug-enable value to write |
| cfg_precise | input | 1 | Precise-mode value to write |
| cfg_ext | input | 1 | External-debug-mode value to write |
| own_wr | input | 1 | Ownership write strobe |
| own_ext_wdata | input | NEV | Ownership value, 1 = external debugger |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | NEV | Status bits to clear |
| clr_imp | input | 1 | Clear the imprecise flag |
| dbg_ext_en | input | 1 | Debug extension enabled |
| status | output | NEV | Sticky event status |
| imprecise | output | 1 | Imprecise-event flag |
| irq | output | 1 | Debug interrupt request |
| dben | output | 1 | Held debug-enable bit |
| precise | output | 1 | Held precise-mode bit |
| extmode | output | 1 | Held external-debug-mode bit |
| own_ext | output | NEV | Held ownership mask |
| use_debug_pair | output | 1 | Save/restore pair select |
| ret_from_enabler | output | 1 | Return address is that of the enabling instruction |

## Verification
Every register result (status, imprecise flag and configuration) is due one edge after its stimulus. The interrupt request has no extra latency: it follows combinationally from those registers, so it is valid in the same cycle as the state that causes it. The bench drives each stimulus on a falling edge and removes it on the next falling edge. All outputs are sampled at that second falling edge, after exactly one rising edge. The sweep covers every event index under every combination of debug-enable, external mode and ownership. A delayed-enable write, a clear, and a check that the request has fallen follow each combination, each sampled one edge later.

// File: rtl/dbg_event_ctrl.sv
module dbg_event_ctrl #(
  parameter int NEV = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_pulse,
  input  logic           cfg_wr,
  input  logic           cfg_en,
  input  logic           cfg_precise,
  input  logic           cfg_ext,
  input  logic           own_wr,
  input  logic [NEV-1:0] own_ext_wdata,
  input  logic           clr_wr,
  input  logic [NEV-1:0] clr_mask,
  input  logic           clr_imp,
  input  logic           dbg_ext_en,
  output logic [NEV-1:0] status,
  output logic           imprecise,
  output logic           irq,
  output logic           dben,
  output logic           precise,
  output logic           extmode,
  output logic [NEV-1:0] own_ext,
  output logic           use_debug_pair,
  output logic           ret_from_enabler
);

  logic [NEV-1:0] kept, fresh, sw_mask;
  logic           imp_set;

  assign kept    = clr_wr ? (status & ~clr_mask) : status;
  assign fresh   = ev_pulse & ~status;
  assign sw_mask = extmode ? ~own_ext : {NEV{1'b1}};
  assign imp_set = !dben && |(fresh & sw_mask);

  assign irq              = dben && |(status & sw_mask);
  assign use_debug_pair   = dbg_ext_en;
  assign ret_from_enabler = imprecise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      imprecise <= 1'b0;
      dben      <= 1'b0;
      precise   <= 1'b0;
      extmode   <= 1'b0;
      own_ext   <= '0;
    end else begin
      status <= kept | ev_pulse;
      if (imp_set)
        imprecise <= 1'b1;
      else if (clr_wr && clr_imp)
        imprecise <= 1'b0;
      if (cfg_wr) begin
        dben    <= cfg_en;
        precise <= cfg_precise;
        extmode <= cfg_ext;
      end
      if (own_wr)
        own_ext <= own_ext_wdata;
    end
  end

  a_r2_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(ev_pulse)) == $past(ev_pulse)));

  a_r3_sticky_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((status & $past(status)) == $past(status)));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> dben);

  a_r7_imp_only_while_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!imprecise && dben) |=> !imprecise);

  a_r8_imp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (imprecise && !(clr_wr && clr_imp)) |=> imprecise);

  a_r10_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !cfg_wr && !own_wr && ev_pulse == '0 &&
     ((status & ~clr_mask & sw_mask) == '0)) |=> !irq);

  a_r11_pair_select: assert property (@(posedge clk) disable iff (!rst_n)
    use_debug_pair == dbg_ext_en);

endmodule

// File: tb/dbg_event_ctrl_bench.sv
module dbg_event_ctrl_bench;
  localparam int NEV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NEV-1:0] ev_pulse = '0, own_ext_wdata = '0, clr_mask = '0;
  logic cfg_wr = 0, cfg_en = 0, cfg_precise = 0, cfg_ext = 0;
  logic own_wr = 0, clr_wr = 0, clr_imp = 0, dbg_ext_en = 0;
  logic [NEV-1:0] status, own_ext;
  logic imprecise, irq, dben, precise, extmode, use_debug_pair, ret_from_enabler;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_event_ctrl #(.NEV(NEV)) u_dbg_event_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_precise(cfg_precise), .cfg_ext(cfg_ext),
    .own_wr(own_wr), .own_ext_wdata(own_ext_wdata),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .clr_imp(clr_imp),
    .dbg_ext_en(dbg_ext_en),
    .status(status), .imprecise(imprecise), .irq(irq),
    .dben(dben), .precise(precise), .extmode(extmode), .own_ext(own_ext),
    .use_debug_pair(use_debug_pair), .ret_from_enabler(ret_from_enabler));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ev_pulse = '0; cfg_wr = 0; own_wr = 0; clr_wr = 0; clr_imp = 0; clr_mask = '0;
  endtask

  task automatic write_cfg(input logic en, input logic pr, input logic ex);
    cfg_wr = 1; cfg_en = en; cfg_precise = pr; cfg_ext = ex;
    step();
  endtask

  task automatic clear_all();
    clr_wr = 1; clr_mask = '1; clr_imp = 1;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(status), 0);
    chk("R1 irq/imp", {imprecise, irq, dben, precise, extmode}, 0);
    chk("R1 own", 32'(own_ext), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NEV; i++) begin
      for (int c = 0; c < 8; c++) begin
        logic en, ex, ow, sw;
        en = c[0]; ex = c[1]; ow = c[2];
        sw = !ex || !ow;
        own_wr = 1; own_ext_wdata = ow ? (NEV'(1) << i) : '0;
        step();
        write_cfg(en, 0, ex);
        clear_all();
        ev_pulse = NEV'(1) << i;
        step();
        chk("R2 status set", 32'(status), 32'(NEV'(1) << i));
        chk("R4/R5/R9 irq", 32'(irq), 32'(en && sw));
        chk("R7/R8 imprecise", 32'(imprecise), 32'(!en && sw));
        chk("R11 ret_from_enabler", 32'(ret_from_enabler), 32'(imprecise));
        if (!en) begin
          write_cfg(1, 1, ex);
          chk("R6 delayed irq", 32'(irq), 32'(sw));
          chk("R6 precise held", 32'(precise), 1);
        end
        clr_wr = 1; clr_mask = NEV'(1) << i;
        step();
        chk("R10 irq falls", 32'(irq), 0);
        chk("R3 cleared", 32'(status), 0);
      end
    end

    // R3: same-cycle event beats clear
    write_cfg(1, 0, 0);
    clear_all();
    ev_pulse = 12'h005; step();
    clr_wr = 1; clr_mask = 12'h005; ev_pulse = 12'h001; step();
    chk("R3 event wins", 32'(status), 32'h001);
    step();
    chk("R3 sticky", 32'(status), 32'h001);

    // R7: re-event on set bit while disabled does not set imprecise
    write_cfg(0, 0, 0);
    clr_wr = 1; clr_imp = 1; step();
    ev_pulse = 12'h001; step();
    chk("R7 no re-set", 32'(imprecise), 0);

    // R8: set wins over clear
    ev_pulse = 12'h010; clr_wr = 1; clr_imp = 1; step();
    chk("R8 set wins", 32'(imprecise), 1);
    clr_wr = 1; clr_imp = 1; step();
    chk("R8 cleared", 32'(imprecise), 0);

    // R9: ownership ignored in non-external mode
    own_wr = 1; own_ext_wdata = '1; step();
    write_cfg(1, 0, 0);
    chk("R9 owner ignored", 32'(irq), 1);

    // R11
    for (int v = 0; v < 2; v++) begin
      dbg_ext_en = v[0]; #1;
      chk("R11 pair", 32'(use_debug_pair), 32'(v));
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule